// File: doc/BRIEF.md
# Two-Level Instruction Dispatcher

This block takes one prefetched instruction (an 8-bit opcode, its address and an upstream-computed branch target) and turns it into a dispatch record for the execution handlers. The dispatch happens in two levels. In the first level, the top two opcode bits act as a length code. That code indexes a four-entry transfer table, which picks one of four format-parse paths and gives the instruction length in halfwords, so the next sequential address follows from it. In the second level, a 256-entry pointer table, indexed by the whole opcode, returns a 32-bit word. This word packs three things: the handler entry address, the bus control byte for main-store accesses, and the real length code. It also packs six side-band bits, which go to control flags together with the entry address.

Before operation, software-side logic fills the pointer table through a write port while the block sits in its load state. A start pulse moves the block into service. Opcodes of the unsupported decimal and floating-point classes do not dispatch and raise an operation exception instead. Pointer words that are malformed also raise the exception. A conditional branch makes two prefetch requests in order: first the next sequential address, then the branch target one cycle later. The input is stalled for that extra cycle.

The controller has three states:
- `ST_LOAD`: table writes are accepted and no instructions are taken.
- `ST_RUN`: one instruction is accepted per cycle.
- `ST_TGT`: the branch-target prefetch is issued and input is held off.

It has four transitions:
- `ST_LOAD`→`ST_RUN` on `start`.
- `ST_RUN`→`ST_TGT` when a conditional branch is dispatched.
- `ST_TGT`→`ST_RUN` unconditionally.
- `ST_RUN`→`ST_RUN` for all other cases.

Top module: `insn_dispatch`

## Requirements
- R1: After reset the block is in `ST_LOAD`, with `in_ready`, `disp_valid`, `op_exc` and `pf_req` all 0.
- R2: In `ST_LOAD` a write with `tbl_we`=1 stores `tbl_wdata` at index `tbl_addr`, and `in_ready` stays 0. A cycle with `start`=1 moves the block to `ST_RUN`, after which `in_ready` is 1.
- R3: Table writes presented while in `ST_RUN` or `ST_TGT` are ignored. A later dispatch of that opcode still returns the word loaded during `ST_LOAD`.
- R4: An instruction accepted at a clock edge (`in_valid`&`in_ready`) produces its result in the cycle after that edge. For a supported opcode with a well-formed word, that result has `disp_valid`=1 and takes its fields from the pointer word: `entry_addr`=word[11:0], `bus_ctl`=word[31:24], `len_code`=word[23:22] and `side_bits`=word[21:16]. Bits [13:12] are ignored.
- R5: On dispatch `fmt_sel` is one-hot, with bit `opcode[7:6]` set.
- R6: `next_pc` = `in_pc` + 2, 4, 4 or 6 for `opcode[7:6]` = 00, 01, 10 or 11, wrapping modulo 2^PC_W.
- R7: Opcodes 0x20–0x3F, 0x60–0x7F and 0xF0–0xFF give `op_exc`=1 and `disp_valid`=0. In that case `entry_addr`, `bus_ctl`, `side_bits` and `fmt_sel` are 0, `len_code` is the halfword count (1, 2 or 3) and no prefetch is requested. `next_pc` still follows R6.
- R8: A pointer word whose bits [15:14] are not 00 is treated exactly as in R7.
- R9: Each non-branch dispatch asserts `pf_req` in the same cycle as `disp_valid`, with `pf_addr`=`next_pc` and `pf_is_tgt`=0.
- R10: The conditional branch opcodes 0x07 and 0x47 first prefetch the sequential address as in R9. In the next cycle they issue `pf_req` with `pf_is_tgt`=1 and `pf_addr` equal to the `in_tgt` captured at acceptance. `in_ready` is 0 during the sequential-prefetch cycle.
- R11: Non-branch instructions are accepted back to back, one per cycle, with no stall, and each accepted instruction yields exactly one of `disp_valid` or `op_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Leave the load state |
| tbl_we | input | 1 | Pointer table write enable |
| tbl_addr | input | 8 | Pointer table write index |
| tbl_wdata | input | 32 | Pointer word to store |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_opcode | input | 8 | Opcode byte |
| in_pc | input | PC_W | Address of the instruction |
| in_tgt | input | PC_W | Branch target address |
| disp_valid | output | 1 | Dispatch record valid |
| op_exc | output | 1 | Operation exception |
| entry_addr | output | 12 | Handler entry address |
| len_code | output | 2 | Length code |
| bus_ctl | output | 8 | Bus control byte |
| side_bits | output | 6 | Control-flag side-band bits |
| fmt_sel | output | 4 | One-hot format-parse path |
| next_pc | output | PC_W | Next sequential address |
| pf_req | output | 1 | Prefetch request |
| pf_is_tgt | output | 1 | Prefetch is the branch target |
| pf_addr | output | PC_W | Prefetch address |

## Verification
The bench builds the block with its default 24-bit program counter. With that width, an instruction placed just below the top of the address space shows the R6 wraparound within one dispatch. All 256 table entries are loaded, so every one of the four format paths, every unsupported opcode class and both branch opcodes are reachable. Two malformed pointer words are placed in different format groups. A branch is placed directly in front of another instruction to expose the target-prefetch stall.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int unsigned OPC_W   = 8;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ENTRY_W = 12;
    localparam int unsigned SIDE_W  = 6;
    localparam int unsigned NFMT    = 4;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_TGT  = 2'd2
    } disp_state_t;

    typedef struct packed {
        logic [7:0]         bus;
        logic [1:0]         ilc;
        logic [SIDE_W-1:0]  side;
        logic [1:0]         must0;
        logic [1:0]         spare;
        logic [ENTRY_W-1:0] entry;
    } ptr_word_t;

    function automatic logic opc_unsupported(input logic [OPC_W-1:0] opc);
        return ((opc[7] == 1'b0) && (opc[5] == 1'b1)) || (opc[7:4] == 4'hF);
    endfunction

    function automatic logic opc_cond_branch(input logic [OPC_W-1:0] opc);
        return (opc[5:0] == 6'h07) && (opc[7] == 1'b0);
    endfunction

endpackage

// File: rtl/dsp_ptr_table.sv
module dsp_ptr_table #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/dsp_fmt_decode.sv
module dsp_fmt_decode
    import dsp_pkg::*;
#(
    parameter int unsigned PC_W   = 24,
    parameter logic [7:0]  HW_MAP = {2'd3, 2'd2, 2'd2, 2'd1}
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [PC_W-1:0]  pc,
    output logic [NFMT-1:0]  fmt_sel,
    output logic [1:0]       hw_count,
    output logic [PC_W-1:0]  next_pc,
    output logic             unsupported,
    output logic             cond_branch
);

    logic [1:0] grp;
    logic [1:0] hw_path [NFMT];
    assign grp = opcode[7:6];

    for (genvar g = 0; g < NFMT; g++) begin : g_path
        assign fmt_sel[g] = (grp == 2'(g));
        assign hw_path[g] = HW_MAP[2*g +: 2];
    end

    assign hw_count    = hw_path[grp];
    assign next_pc     = pc + PC_W'({hw_count, 1'b0});
    assign unsupported = opc_unsupported(opcode);
    assign cond_branch = opc_cond_branch(opcode);

endmodule

// File: rtl/insn_dispatch.sv
module insn_dispatch
    import dsp_pkg::*;
#(
    parameter int unsigned PC_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tbl_we,
    input  logic [7:0]         tbl_addr,
    input  logic [31:0]        tbl_wdata,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_opcode,
    input  logic [PC_W-1:0]    in_pc,
    input  logic [PC_W-1:0]    in_tgt,
    output logic               disp_valid,
    output logic               op_exc,
    output logic [11:0]        entry_addr,
    output logic [1:0]         len_code,
    output logic [7:0]         bus_ctl,
    output logic [5:0]         side_bits,
    output logic [3:0]         fmt_sel,
    output logic [PC_W-1:0]    next_pc,
    output logic               pf_req,
    output logic               pf_is_tgt,
    output logic [PC_W-1:0]    pf_addr
);

    localparam int unsigned ENTRIES = 1 << OPC_W;

    disp_state_t state_q, state_d;

    logic [WORD_W-1:0] rd_word;
    ptr_word_t         ptr;
    logic [NFMT-1:0]   dec_fmt;
    logic [1:0]        dec_hw;
    logic [PC_W-1:0]   dec_npc;
    logic              dec_unsup;
    logic              dec_branch;
    logic              accept;
    logic              bad;
    logic              tbl_wr_ok;
    logic [PC_W-1:0]   tgt_q;
    logic [1:0]        unused_spare;

    assign in_ready     = (state_q == ST_RUN);
    assign accept       = in_valid && in_ready;
    assign tbl_wr_ok    = tbl_we && (state_q == ST_LOAD);
    assign ptr          = ptr_word_t'(rd_word);
    assign unused_spare = ptr.spare;
    assign bad          = dec_unsup || (ptr.must0 != 2'b00);

    dsp_ptr_table #(
        .ENTRIES (ENTRIES),
        .DATA_W  (WORD_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr_ok),
        .wr_idx  (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_idx  (in_opcode),
        .rd_data (rd_word)
    );

    dsp_fmt_decode #(
        .PC_W (PC_W)
    ) u_fmt (
        .opcode      (in_opcode),
        .pc          (in_pc),
        .fmt_sel     (dec_fmt),
        .hw_count    (dec_hw),
        .next_pc     (dec_npc),
        .unsupported (dec_unsup),
        .cond_branch (dec_branch)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (accept && !bad && dec_branch) state_d = ST_TGT;
            end
            ST_TGT: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            op_exc     <= 1'b0;
            entry_addr <= '0;
            len_code   <= '0;
            bus_ctl    <= '0;
            side_bits  <= '0;
            fmt_sel    <= '0;
            next_pc    <= '0;
            pf_req     <= 1'b0;
            pf_is_tgt  <= 1'b0;
            pf_addr    <= '0;
            tgt_q      <= '0;
        end else begin
            disp_valid <= 1'b0;
            op_exc     <= 1'b0;
            pf_req     <= 1'b0;
            pf_is_tgt  <= 1'b0;
            unique case (state_q)
                ST_LOAD: begin
                end
                ST_RUN: begin
                    if (accept) begin
                        next_pc <= dec_npc;
                        if (bad) begin
                            op_exc     <= 1'b1;
                            entry_addr <= '0;
                            bus_ctl    <= '0;
                            side_bits  <= '0;
                            fmt_sel    <= '0;
                            len_code   <= dec_hw;
                        end else begin
                            disp_valid <= 1'b1;
                            entry_addr <= ptr.entry;
                            bus_ctl    <= ptr.bus;
                            side_bits  <= ptr.side;
                            len_code   <= ptr.ilc;
                            fmt_sel    <= dec_fmt;
                            pf_req     <= 1'b1;
                            pf_addr    <= dec_npc;
                            if (dec_branch) tgt_q <= in_tgt;
                        end
                    end
                end
                ST_TGT: begin
                    pf_req    <= 1'b1;
                    pf_is_tgt <= 1'b1;
                    pf_addr   <= tgt_q;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/insn_dispatch_chk.sv
module insn_dispatch_chk #(
    parameter int unsigned PC_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            disp_valid,
    input logic            op_exc,
    input logic [11:0]     entry_addr,
    input logic [5:0]      side_bits,
    input logic [3:0]      fmt_sel,
    input logic [PC_W-1:0] next_pc,
    input logic            pf_req,
    input logic            pf_is_tgt,
    input logic [PC_W-1:0] pf_addr
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!disp_valid && !op_exc && !pf_req && !in_ready));

    p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (disp_valid != op_exc));

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (!disp_valid && !op_exc));

    p_fmt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ($countones(fmt_sel) == 1));

    p_exc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_exc |-> (!pf_req && entry_addr == '0 && side_bits == '0 && fmt_sel == '0));

    p_seq_pf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (pf_req && !pf_is_tgt && pf_addr == next_pc));

    p_tgt_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !in_ready) |=> (pf_req && pf_is_tgt && !disp_valid && !op_exc));

endmodule

bind insn_dispatch insn_dispatch_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .disp_valid (disp_valid),
    .op_exc     (op_exc),
    .entry_addr (entry_addr),
    .side_bits  (side_bits),
    .fmt_sel    (fmt_sel),
    .next_pc    (next_pc),
    .pf_req     (pf_req),
    .pf_is_tgt  (pf_is_tgt),
    .pf_addr    (pf_addr)
);

// File: tb/insn_dispatch_test.sv
module insn_dispatch_test;

    localparam int PC_W = 24;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n, start, tbl_we, in_valid, in_ready;
    logic [7:0]      tbl_addr, in_opcode;
    logic [31:0]     tbl_wdata;
    logic [PC_W-1:0] in_pc, in_tgt, next_pc, pf_addr;
    logic            disp_valid, op_exc, pf_req, pf_is_tgt;
    logic [11:0]     entry_addr;
    logic [1:0]      len_code;
    logic [7:0]      bus_ctl;
    logic [5:0]      side_bits;
    logic [3:0]      fmt_sel;

    insn_dispatch #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_opcode(in_opcode), .in_pc(in_pc),
        .in_tgt(in_tgt), .disp_valid(disp_valid), .op_exc(op_exc),
        .entry_addr(entry_addr), .len_code(len_code), .bus_ctl(bus_ctl),
        .side_bits(side_bits), .fmt_sel(fmt_sel), .next_pc(next_pc),
        .pf_req(pf_req), .pf_is_tgt(pf_is_tgt), .pf_addr(pf_addr)
    );

    typedef struct packed {
        logic            exc;
        logic [11:0]     entry;
        logic [7:0]      bus;
        logic [1:0]      len;
        logic [5:0]      side;
        logic [3:0]      fmt;
        logic [PC_W-1:0] npc;
        logic            br;
        logic [PC_W-1:0] tgt;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] shadow [256];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    bit          done  = 0;
    bit          tgt_pend = 0;
    logic [PC_W-1:0] tgt_exp;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int op);
        logic [1:0] m0;
        m0 = (op == 8'h1B) ? 2'b10 : (op == 8'h9C) ? 2'b01 : 2'b00;
        return {8'(op ^ 8'hA5), 2'(op ^ 1), 6'(op ^ 6'h15), m0, 2'(op), 12'(op * 5 + 16)};
    endfunction

    function automatic logic [1:0] hw_of(input logic [7:0] op);
        case (op[7:6])
            2'b00:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    task automatic issue(input logic [7:0] op, input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt);
        exp_t        e;
        logic [31:0] w;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_pc = pc; in_tgt = tgt;
        w     = shadow[op];
        e.exc = ((op[7] == 1'b0 && op[5] == 1'b1) || op[7:4] == 4'hF) || (w[15:14] != 2'b00);
        e.npc = pc + PC_W'({hw_of(op), 1'b0});
        e.br  = !e.exc && (op == 8'h07 || op == 8'h47);
        e.tgt = tgt;
        if (e.exc) begin
            e.entry = '0; e.bus = '0; e.side = '0; e.fmt = '0; e.len = hw_of(op);
        end else begin
            e.entry = w[11:0]; e.bus = w[31:24]; e.len = w[23:22];
            e.side = w[21:16]; e.fmt = 4'(1 << op[7:6]);
        end
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tbl_write(input logic [7:0] a, input logic [31:0] d);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tgt_pend) begin
                tgt_pend = 0;
                check(pf_req && pf_is_tgt && pf_addr == tgt_exp && !in_valid_taken_result(),
                      "R10 target prefetch", {pf_req, pf_is_tgt, pf_addr}, {2'b11, tgt_exp});
            end
            if (disp_valid || op_exc) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected result", 96'(entry_addr), 96'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({op_exc, disp_valid, entry_addr, bus_ctl, len_code, side_bits, fmt_sel, next_pc} ==
                          {e.exc, !e.exc, e.entry, e.bus, e.len, e.side, e.fmt, e.npc},
                          e.exc ? "R7/R8 exception record" : "R4/R5/R6 dispatch record",
                          {op_exc, disp_valid, entry_addr, bus_ctl, len_code, side_bits, fmt_sel, next_pc},
                          {e.exc, !e.exc, e.entry, e.bus, e.len, e.side, e.fmt, e.npc});
                    if (e.exc)
                        check(!pf_req, "R7 no prefetch on exception", 96'(pf_req), 96'(0));
                    else
                        check(pf_req && !pf_is_tgt && pf_addr == e.npc, "R9 sequential prefetch",
                              {pf_req, pf_is_tgt, pf_addr}, {2'b10, e.npc});
                    if (e.br) begin
                        check(!in_ready, "R10 input stall", 96'(in_ready), 96'(0));
                        tgt_pend = 1;
                        tgt_exp  = e.tgt;
                    end
                end
            end
        end
    end

    function automatic bit in_valid_taken_result();
        return disp_valid || op_exc;
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t0;
        rst_n = 1'b0; start = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
        in_valid = 1'b0; in_opcode = '0; in_pc = '0; in_tgt = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!in_ready && !disp_valid && !op_exc && !pf_req, "R1 reset outputs",
              {in_ready, disp_valid, op_exc, pf_req}, 96'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready, "R1 load state after reset", 96'(in_ready), 96'(0));

        // R2: load the table
        for (int i = 0; i < 256; i++) begin
            shadow[i] = mk_word(i);
            tbl_write(8'(i), shadow[i]);
        end
        check(!in_ready, "R2 not ready while loading", 96'(in_ready), 96'(0));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready, "R2 ready after start", 96'(in_ready), 96'(1));

        // R4/R5/R6: each format group
        issue(8'h1A, 24'h001000, '0);
        issue(8'h58, 24'h002000, '0);
        issue(8'h90, 24'h003002, '0);
        issue(8'hD2, 24'h004004, '0);
        // R6: wraparound
        issue(8'hD2, 24'hFFFFFC, '0);
        issue(8'h5A, 24'hFFFFFE, '0);
        // R7: unsupported classes
        issue(8'h2A, 24'h000100, '0);
        issue(8'h7E, 24'h000200, '0);
        issue(8'hF3, 24'h000300, '0);
        // R8: malformed pointer words
        issue(8'h1B, 24'h000400, '0);
        issue(8'h9C, 24'h000500, '0);
        // R10: branches, each followed at once by another instruction
        issue(8'h47, 24'h000600, 24'h00ABC0);
        issue(8'h18, 24'h000604, '0);
        issue(8'h07, 24'h000700, 24'h123456);
        issue(8'h41, 24'h000702, '0);

        // R3: writes in run state are ignored
        tbl_write(8'h58, 32'hFFFF_0FFF);
        issue(8'h58, 24'h000800, '0);

        // R11: back-to-back throughput
        t0 = cyc;
        for (int k = 0; k < 8; k++) issue(8'(8'h10 + k * 8'h11), 24'(24'h010000 + k * 6), '0);
        check((cyc - t0) == 8, "R11 one per cycle", 96'(cyc - t0), 96'(8));

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R11 all results delivered", 96'(sb.size()), 96'(0));
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule